// File: doc/BRIEF.md
# Four-Phase Handshake Data Multiplexer

This block merges two passive push channels onto one active push channel. Each channel uses a request level, an acknowledge level and a data bus. All of them are sampled on a single clock. When an input raises its request, the block captures that input's data into an output register. One clock later it raises the output request, so the data is already settled when the request rises.

The block then runs a full four-phase handshake on the output. The input's acknowledge rises together with the output request's fall, which is the cycle after the output acknowledge is seen high. Once the output acknowledge has dropped again, the output data is cleared to zero. The block then waits for the selected input to drop its request and releases that input's acknowledge. The output handshake is therefore nested inside the input handshake.

The two input requests are assumed never to be high together. The block does not arbitrate between them. It gives input a precedence only when both rise in the same idle cycle, and it records any overlap in a sticky error flag. A selected input keeps the channel until its own return-to-zero phase is complete.

Top module: `hs_mux`

## Requirements
- R1: While reset is asserted and directly after it, the following are all low or zero: the output request, both input acknowledges, the output data and the error flag.
- R2: One cycle after an idle block samples an input request, the output data holds that input's data while the output request is still low. On the next cycle the output request rises and the data is unchanged. Changes on the input data after that first cycle are not copied.
- R3: The output data stays constant from the rise of the output request until the output acknowledge is seen low again, for any acknowledge delay.
- R4: The output request stays high until the output acknowledge is sampled high. It falls on the next cycle, and the selected input's acknowledge rises in that same cycle.
- R5: The cycle after the output acknowledge is sampled low following a transfer, the output data reads zero.
- R6: The selected input's acknowledge stays high for as long as that input's request stays high. It falls one cycle after the request is sampled low.
- R7: While one input is being served, the other input's acknowledge stays low, and a request on it does not alter the output data.
- R8: The error flag goes high one cycle after both input requests are sampled high together. It then stays high until reset.
- R9: If both requests are first sampled high in the same idle cycle, input a is served. Its data appears on the output and only its acknowledge rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_req | input | 1 | Input a request |
| a_ack | output | 1 | Input a acknowledge |
| a_data | input | DATA_W | Input a data |
| b_req | input | 1 | Input b request |
| b_ack | output | 1 | Input b acknowledge |
| b_data | input | DATA_W | Input b data |
| c_req | output | 1 | Output request |
| c_ack | input | 1 | Output acknowledge |
| c_data | output | DATA_W | Output data, zero outside a transfer |
| proto_err | output | 1 | Sticky flag: both input requests seen high together |

## Verification
The hardest situation to bring about is an overlap of the two input requests. A correct environment never produces one, yet the error flag, the precedence rule and the protection of the selected transfer all depend on it. The stimulus creates the overlap deliberately in two ways. In one, the second request is raised while the first transfer waits for the output acknowledge. In the other, both requests rise in the same idle cycle. Each case is followed by a reset to show that the flag is cleared. Outside those cases the sweep covers every data value on both inputs, and it varies the acknowledge delays and how long each input holds its request.

// File: rtl/hs_mux_pkg.sv
package hs_mux_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOAD  = 3'd1,
        ST_RAISE = 3'd2,
        ST_FALL  = 3'd3,
        ST_HOLD  = 3'd4
    } mux_st_e;

    typedef enum logic {
        SRC_A = 1'b0,
        SRC_B = 1'b1
    } mux_src_e;

    typedef struct packed {
        mux_st_e  st;
        mux_src_e src;
        logic     c_req;
        logic     a_ack;
        logic     b_ack;
    } fsm_regs_t;

endpackage

// File: rtl/hs_mux_guard.sv
module hs_mux_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic a_req,
    input  logic b_req,
    output logic err
);
    logic err_d;
    logic err_q;

    always_comb begin
        err_d = err_q | (a_req & b_req);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;
endmodule

// File: rtl/hs_mux_fsm.sv
module hs_mux_fsm
    import hs_mux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_req,
    input  logic b_req,
    input  logic c_ack,
    output logic c_req,
    output logic a_ack,
    output logic b_ack,
    output logic load,
    output logic pick_b,
    output logic clear
);
    fsm_regs_t r_d;
    fsm_regs_t r_q;
    logic      own_req;

    always_comb begin
        r_d     = r_q;
        load    = 1'b0;
        pick_b  = 1'b0;
        clear   = 1'b0;
        own_req = (r_q.src == SRC_A) ? a_req : b_req;
        case (r_q.st)
            ST_IDLE: begin
                if (a_req || b_req) begin
                    load   = 1'b1;
                    pick_b = !a_req;
                    r_d.src = a_req ? SRC_A : SRC_B;
                    r_d.st  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                r_d.c_req = 1'b1;
                r_d.st    = ST_RAISE;
            end
            ST_RAISE: begin
                if (c_ack) begin
                    r_d.c_req = 1'b0;
                    if (r_q.src == SRC_A) begin
                        r_d.a_ack = 1'b1;
                    end else begin
                        r_d.b_ack = 1'b1;
                    end
                    r_d.st = ST_FALL;
                end
            end
            ST_FALL: begin
                if (!c_ack) begin
                    clear  = 1'b1;
                    r_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!own_req) begin
                    r_d.a_ack = 1'b0;
                    r_d.b_ack = 1'b0;
                    r_d.st    = ST_IDLE;
                end
            end
            default: begin
                r_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign c_req = r_q.c_req;
    assign a_ack = r_q.a_ack;
    assign b_ack = r_q.b_ack;
endmodule

// File: rtl/hs_mux_dreg.sv
module hs_mux_dreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              pick_b,
    input  logic              clear,
    input  logic [DATA_W-1:0] a_data,
    input  logic [DATA_W-1:0] b_data,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] q_d;
    logic [DATA_W-1:0] q_q;

    always_comb begin
        q_d = q_q;
        if (load) begin
            q_d = pick_b ? b_data : a_data;
        end else if (clear) begin
            q_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign q = q_q;
endmodule

// File: rtl/hs_mux.sv
module hs_mux #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_req,
    output logic              a_ack,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_req,
    output logic              b_ack,
    input  logic [DATA_W-1:0] b_data,
    output logic              c_req,
    input  logic              c_ack,
    output logic [DATA_W-1:0] c_data,
    output logic              proto_err
);
    logic load;
    logic pick_b;
    logic clear;

    hs_mux_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_req  (a_req),
        .b_req  (b_req),
        .c_ack  (c_ack),
        .c_req  (c_req),
        .a_ack  (a_ack),
        .b_ack  (b_ack),
        .load   (load),
        .pick_b (pick_b),
        .clear  (clear)
    );

    hs_mux_dreg #(.DATA_W(DATA_W)) u_dreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .pick_b (pick_b),
        .clear  (clear),
        .a_data (a_data),
        .b_data (b_data),
        .q      (c_data)
    );

    hs_mux_guard u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .a_req (a_req),
        .b_req (b_req),
        .err   (proto_err)
    );
endmodule

// File: rtl/hs_mux_chk.sv
module hs_mux_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_req,
    input logic              a_ack,
    input logic              b_req,
    input logic              b_ack,
    input logic              c_req,
    input logic              c_ack,
    input logic [DATA_W-1:0] c_data,
    input logic              proto_err
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!c_req && !a_ack && !b_ack && c_data == '0 && !proto_err)
                else $error("R1 outputs not quiet in reset");
        end
    end

    a_r2_data_settled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_req) |-> $stable(c_data));

    a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && $past(c_req)) |-> $stable(c_data));

    a_r4_ack_a_with_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_ack) |-> $fell(c_req));

    a_r4_ack_b_with_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_ack) |-> $fell(c_req));

    a_r6_ack_a_held: assert property (@(posedge clk) disable iff (!rst_n)
        (a_ack && a_req) |=> a_ack);

    a_r6_ack_b_held: assert property (@(posedge clk) disable iff (!rst_n)
        (b_ack && b_req) |=> b_ack);

    a_r7_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ack && b_ack));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind hs_mux hs_mux_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_req     (a_req),
    .a_ack     (a_ack),
    .b_req     (b_req),
    .b_ack     (b_ack),
    .c_req     (c_req),
    .c_ack     (c_ack),
    .c_data    (c_data),
    .proto_err (proto_err)
);

// File: tb/sim_hs_mux.sv
`timescale 1ns/1ps
module sim_hs_mux;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         a_req = 1'b0;
    logic         b_req = 1'b0;
    logic         c_ack = 1'b0;
    logic [W-1:0] a_data = '0;
    logic [W-1:0] b_data = '0;
    logic         a_ack;
    logic         b_ack;
    logic         c_req;
    logic [W-1:0] c_data;
    logic         proto_err;

    int checks = 0;
    int failures = 0;
    logic err_exp = 1'b0;

    always #2 clk = ~clk;

    hs_mux #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_req(a_req), .a_ack(a_ack), .a_data(a_data),
        .b_req(b_req), .b_ack(b_ack), .b_data(b_data),
        .c_req(c_req), .c_ack(c_ack), .c_data(c_data),
        .proto_err(proto_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_req(input bit s, input logic v);
        if (s) b_req = v; else a_req = v;
    endtask

    function automatic logic my_ack(input bit s);
        return s ? b_ack : a_ack;
    endfunction

    function automatic logic other_ack(input bit s);
        return s ? a_ack : b_ack;
    endfunction

    // mode 0: clean transfer, 1: other input intrudes while waiting, 2: both rise together (s=0)
    task automatic xfer(input bit s, input logic [W-1:0] v, input int lat, input int lat2,
                        input int hold, input int mode);
        @(negedge clk);
        if (s) b_data = v; else a_data = v;
        if (s) a_data = ~v; else b_data = ~v;
        set_req(s, 1'b1);
        if (mode == 2) begin
            set_req(!s, 1'b1);
            err_exp = 1'b1;
        end
        @(negedge clk);
        chk("R2 req low while data loads", c_req, 0);
        chk(mode == 2 ? "R9 chosen data" : "R2 data loaded", c_data, v);
        chk("R8 error flag", proto_err, err_exp);
        if (mode == 2) set_req(!s, 1'b0);
        if (s) b_data = v ^ 8'h5A; else a_data = v ^ 8'h5A;
        @(negedge clk);
        chk("R2 req raised", c_req, 1);
        chk("R2 data not recaptured", c_data, v);
        if (mode == 1) begin
            set_req(!s, 1'b1);
            if (s) a_data = ~v; else b_data = ~v;
            @(negedge clk);
            err_exp = 1'b1;
            chk("R8 error on overlap", proto_err, 1);
            chk("R7 other ack low", other_ack(s), 0);
            chk("R7 data kept", c_data, v);
            set_req(!s, 1'b0);
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R4 req held until ack", c_req, 1);
            chk("R4 input ack waits", my_ack(s), 0);
            chk("R3 data held", c_data, v);
        end
        c_ack = 1'b1;
        @(negedge clk);
        chk("R4 req dropped", c_req, 0);
        chk(mode == 2 ? "R9 selected ack" : "R4 input ack", my_ack(s), 1);
        chk("R7 other ack low", other_ack(s), 0);
        chk("R3 data held at ack", c_data, v);
        for (int i = 0; i < lat2; i++) begin
            @(negedge clk);
            chk("R3 data held until rtz", c_data, v);
            chk("R4 req stays low", c_req, 0);
        end
        c_ack = 1'b0;
        @(negedge clk);
        chk("R5 data cleared", c_data, 0);
        chk("R6 ack held", my_ack(s), 1);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R6 ack held while req", my_ack(s), 1);
        end
        set_req(s, 1'b0);
        @(negedge clk);
        chk("R6 ack released", my_ack(s), 0);
        chk("R7 other ack low", other_ack(s), 0);
        chk("R8 error flag", proto_err, err_exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a_req = 1'b0;
        b_req = 1'b0;
        c_ack = 1'b0;
        err_exp = 1'b0;
        @(negedge clk);
        chk("R1 c_req reset", c_req, 0);
        chk("R1 acks reset", {a_ack, b_ack}, 0);
        chk("R1 data reset", c_data, 0);
        chk("R1 error reset", proto_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 quiet after reset", {c_req, a_ack, b_ack, proto_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        for (int s = 0; s < 2; s++) begin
            for (int v = 0; v < 256; v++) begin
                xfer(s[0], v[W-1:0], v % 3, (v / 3) % 3, (v / 9) % 2, 0);
            end
        end
        xfer(1'b0, 8'hA5, 2, 1, 1, 1);
        xfer(1'b1, 8'h3C, 0, 0, 0, 0);
        do_reset();
        xfer(1'b1, 8'h96, 1, 2, 0, 1);
        do_reset();
        xfer(1'b0, 8'h3C, 1, 1, 1, 2);
        do_reset();
        xfer(1'b0, 8'h81, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule